// File: doc/BRIEF.md
# Serial-to-Parallel Display Bridge

This block lets a serial SPI master drive a wide parallel display bus. On the write side, MOSI bits are shifted into a word-wide register, most significant bit first. A rising edge on the write strobe then copies the whole word onto the parallel output pins. Those pins hold the word until the next strobe.

On the read side, a falling edge on the read strobe captures the parallel input bus into a second, independent register. That register is then shifted out on MISO, most significant bit first, on falling SPI clock edges. Chip select (active low) gates all shifting on both sides and enables the MISO driver.

A bit counter on the write side raises an error flag when a strobe latches a word before a full word of bits has arrived since the previous latch.

All pins are sampled by a fast system clock through a short register chain. Each edge is detected in that clock's domain, so every SPI clock, strobe and chip-select event must last several system clock cycles.

Top module: `spi_par_bridge`

## Requirements
- R1: After reset, the parallel output is all zeros, the error flag is low and the MISO enable is low.
- R2: While chip select is low, each rising SPI clock edge shifts MOSI into the write register, most significant bit first, so that the first of 24 bits lands in bit 23.
- R3: While chip select is high, SPI clock edges shift neither register, and the MISO enable is low (MISO is high impedance). While chip select is low, the MISO enable is high.
- R4: A rising edge of the write strobe copies the write register onto the parallel output. Without such an edge, the parallel output keeps its value even while bits are shifted in.
- R5: On each write strobe, the error flag is set if fewer than 24 bits were shifted since the previous strobe (or reset), and cleared otherwise. With more than 24 bits, the last 24 are latched.
- R6: A falling edge of the read strobe loads the parallel input into the read register. Its bit 23 appears on MISO before the first falling SPI clock edge.
- R7: Each falling SPI clock edge with chip select low moves the next lower bit onto MISO. After all 24 bits have been shifted out, MISO reads zero.
- R8: Loading the read register does not disturb the write register, its bit count, or the parallel output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI clock from the master |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial read-back data; high impedance when deselected |
| miso_oe | output | 1 | High while MISO is driven |
| wr_stb | input | 1 | Write strobe; latches on its rising edge |
| rd_stb | input | 1 | Read strobe; loads on its falling edge |
| par_in | input | WORD_W | Parallel bus read back from the display |
| par_out | output | WORD_W | Parallel bus written to the display |
| short_err | output | 1 | Set by a strobe that follows a short word |

## Verification
The assertions assume that every level on sclk, cs_n, wr_stb and rd_stb lasts for more than the synchronizer depth in system clock cycles. They also assume that MOSI and chip select are stable around each SPI clock edge, and that a write strobe edge does not coincide with an SPI clock edge. The bench keeps to these conditions by holding each SPI half period for six system clocks and each strobe level for at least four. It changes MOSI only at a falling SPI clock edge and asserts the strobes only between bursts. The random stimulus varies the word values, the burst lengths (short, exact and long) and the read-back words, but never the spacing of edges.

// File: rtl/spb_pkg.sv
package spb_pkg;
  typedef enum logic [1:0] {
    SYNC_LEVEL = 2'd0,
    SYNC_RISE  = 2'd1,
    SYNC_FALL  = 2'd2
  } sync_mode_e;
endpackage

// File: rtl/spb_sync.sv
module spb_sync
  import spb_pkg::*;
#(
  parameter int             N      = 1,
  parameter int             STAGES = 2,
  parameter logic [N-1:0]   IDLE   = '0,
  parameter logic [2*N-1:0] MODES  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= IDLE;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    localparam sync_mode_e M = sync_mode_e'(MODES[2*i +: 2]);
    if (M == SYNC_LEVEL) begin : g_lvl
      assign q[i] = chain[STAGES-1][i];
    end else begin : g_edge
      logic prev;
      always_ff @(posedge clk) begin
        if (rst) prev <= IDLE[i];
        else     prev <= chain[STAGES-1][i];
      end
      if (M == SYNC_RISE) begin : g_r
        assign q[i] = chain[STAGES-1][i] & ~prev;
      end else begin : g_f
        assign q[i] = ~chain[STAGES-1][i] & prev;
      end
      // R2: an edge event is a single-cycle pulse
      a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        q[i] |=> !q[i]);
    end
  end
endmodule

// File: rtl/spb_wr_path.sv
module spb_wr_path #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              din,
  input  logic              latch,
  output logic [WORD_W-1:0] par_out,
  output logic              short_err
);
  localparam int CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] FULL = CW'(WORD_W);

  logic [WORD_W-1:0] sreg;
  logic [CW-1:0]     cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg      <= '0;
      cnt       <= '0;
      par_out   <= '0;
      short_err <= 1'b0;
    end else begin
      if (shift_en) sreg <= {sreg[WORD_W-2:0], din};
      if (latch) begin
        par_out   <= sreg;
        short_err <= (cnt < FULL);
        cnt       <= shift_en ? CW'(1) : '0;
      end else if (shift_en && cnt != FULL) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  a_r4_latch: assert property (@(posedge clk) disable iff (rst)
    latch |=> par_out == $past(sreg));
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !latch |=> $stable(par_out));
  a_r3_no_shift: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sreg));
  a_r5_full_clears: assert property (@(posedge clk) disable iff (rst)
    (latch && cnt == FULL) |=> !short_err);
  always_comb begin
    if (!rst) a_r5_cnt_bound: assert (cnt <= FULL);
  end
endmodule

// File: rtl/spb_rd_path.sv
module spb_rd_path #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift_en,
  input  logic              sel,
  input  logic [WORD_W-1:0] par_in,
  output logic              miso_bit,
  output logic              oe
);
  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      oe   <= 1'b0;
    end else begin
      oe <= sel;
      if (load)          sreg <= par_in;
      else if (shift_en) sreg <= {sreg[WORD_W-2:0], 1'b0};
    end
  end

  assign miso_bit = sreg[WORD_W-1];

  a_r6_load: assert property (@(posedge clk) disable iff (rst)
    load |=> sreg == $past(par_in));
  a_r7_drain: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !load) |=> $countones(sreg) <= $past($countones(sreg)));
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !load) |=> $stable(sreg));
endmodule

// File: rtl/spi_par_bridge.sv
module spi_par_bridge
  import spb_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [WORD_W-1:0] par_in,
  output logic [WORD_W-1:0] par_out,
  output logic              short_err
);
  localparam int NPIN    = 6;
  localparam int P_CS    = 0;
  localparam int P_MOSI  = 1;
  localparam int P_SRISE = 2;
  localparam int P_SFALL = 3;
  localparam int P_WR    = 4;
  localparam int P_RD    = 5;
  localparam logic [NPIN-1:0]   PIN_IDLE  = 6'b110001;
  localparam logic [2*NPIN-1:0] PIN_MODES = {SYNC_FALL, SYNC_RISE, SYNC_FALL,
                                             SYNC_RISE, SYNC_LEVEL, SYNC_LEVEL};

  logic [NPIN-1:0] pin_raw, pin_q;
  logic            wr_shift, rd_shift, selected, miso_bit;

  assign pin_raw = {rd_stb, wr_stb, sclk, sclk, mosi, cs_n};

  spb_sync #(
    .N(NPIN), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE), .MODES(PIN_MODES)
  ) u_sync (
    .clk(clk), .rst(rst), .d(pin_raw), .q(pin_q)
  );

  assign selected = ~pin_q[P_CS];
  assign wr_shift = pin_q[P_SRISE] & selected;
  assign rd_shift = pin_q[P_SFALL] & selected;

  spb_wr_path #(.WORD_W(WORD_W)) u_wr (
    .clk(clk), .rst(rst), .shift_en(wr_shift), .din(pin_q[P_MOSI]),
    .latch(pin_q[P_WR]), .par_out(par_out), .short_err(short_err)
  );

  spb_rd_path #(.WORD_W(WORD_W)) u_rd (
    .clk(clk), .rst(rst), .load(pin_q[P_RD]), .shift_en(rd_shift),
    .sel(selected), .par_in(par_in), .miso_bit(miso_bit), .oe(miso_oe)
  );

  assign miso = miso_oe ? miso_bit : 1'bz;

  a_r3_oe_off: assert property (@(posedge clk) disable iff (rst)
    !selected |=> !miso_oe);
  a_r3_oe_on: assert property (@(posedge clk) disable iff (rst)
    selected |=> miso_oe);
endmodule

// File: tb/spi_par_bridge_bench.sv
module spi_par_bridge_bench;
  localparam int W    = 24;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, wr_stb = 1'b1, rd_stb = 1'b1;
  logic [W-1:0] par_in = '0;
  logic [W-1:0] par_out;
  logic miso, miso_oe, short_err;

  int n_checks = 0;
  int n_fail   = 0;
  logic [W-1:0] wmodel = '0;
  int wcount = 0;

  always #4 clk = ~clk;

  spi_par_bridge u_spi_par_bridge (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .par_in(par_in), .par_out(par_out), .short_err(short_err)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [W-1:0] w, input int n);
    logic [31:0] r = '0;
    for (int k = 0; k < n; k++) r = {r[30:0], (k < W) ? w[W-1-k] : 1'b0};
    return r;
  endfunction

  // Shift n bits MSB first; capture MISO just before each rising edge.
  task automatic spi_bits(input logic [31:0] data, input int n, output logic [31:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      mosi = data[n-1-i];
      tick(HALF);
      got = {got[30:0], miso};
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
    tick(HALF);
    if (!cs_n) begin
      for (int i = 0; i < n; i++) wmodel = {wmodel[W-2:0], data[n-1-i]};
      wcount = (wcount + n > W) ? W : wcount + n;
    end
  endtask

  task automatic strobe_wr();
    wr_stb = 1'b0; tick(4);
    wr_stb = 1'b1; tick(6);
  endtask

  task automatic strobe_rd();
    rd_stb = 1'b0; tick(6);
    rd_stb = 1'b1; tick(4);
  endtask

  task automatic write_check(input string req);
    logic exp_err;
    exp_err = (wcount < W);
    strobe_wr();
    wcount = 0;
    check(req, 32'(par_out), 32'(wmodel));
    check(req, 32'(short_err), 32'(exp_err));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] got;
    logic [W-1:0] old;
    void'($urandom(32'd7321));
    tick(5);
    rst = 1'b0;
    tick(2);
    // R1 reset state
    check("R1 par_out", 32'(par_out), 32'h0);
    check("R1 short_err", 32'(short_err), 32'h0);
    check("R1 miso_oe", 32'(miso_oe), 32'h0);

    // R3 enable follows chip select
    cs_n = 1'b0; tick(6);
    check("R3 oe on", 32'(miso_oe), 32'h1);

    // R2 R4 R5 full word
    spi_bits(32'h00A5C33C, 24, got);
    write_check("R2 R4 full word");

    // R4 hold while shifting, then R5 short word
    old = par_out;
    spi_bits(32'h0000005A, 8, got);
    check("R4 hold", 32'(par_out), 32'(old));
    write_check("R5 short word");

    // R5 long word keeps last 24
    spi_bits(32'h0DEADBEE, 28, got);
    write_check("R5 long word");

    // R3 gating: full word, then deselected clocks must not shift
    spi_bits(32'h00123456, 24, got);
    cs_n = 1'b1; tick(6);
    check("R3 oe off", 32'(miso_oe), 32'h0);
    spi_bits(32'h00000FFF, 12, got);
    cs_n = 1'b0; tick(6);
    write_check("R3 gated shift");

    // R6 R7 read-back, with excess clocks returning zero
    par_in = 24'h81F00F;
    strobe_rd();
    par_in = 24'h3C3C3C;
    spi_bits(32'h0, 26, got);
    check("R6 R7 read", got & 32'h03FFFFFF, exp_read(24'h81F00F, 26));
    write_check("R7 write side during read");

    // R8 read load in the middle of a write word
    spi_bits(32'h00000ABC, 12, got);
    par_in = 24'hC0FFEE;
    strobe_rd();
    spi_bits(32'h00000DEF, 12, got);
    check("R8 read after mid-word load", got & 32'hFFF, exp_read(24'hC0FFEE, 12));
    write_check("R8 write word intact");

    // Random mix
    for (int it = 0; it < 40; it++) begin
      int sel_n;
      int n;
      logic [31:0] data;
      logic [W-1:0] rw;
      sel_n = int'($urandom % 4);
      n = (sel_n < 2) ? W : (sel_n == 2) ? 1 + int'($urandom % 23) : 25 + int'($urandom % 6);
      data = $urandom;
      rw = W'($urandom);
      par_in = rw;
      strobe_rd();
      spi_bits(data, n, got);
      check("R7 random read", got & ((n >= 32) ? 32'hFFFFFFFF : ((32'h1 << n) - 1)), exp_read(rw, n));
      write_check("R5 random write");
    end

    cs_n = 1'b1; tick(6);
    check("R3 oe off at end", 32'(miso_oe), 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule